// File: doc/BRIEF.md
# Posted-Write Store Buffer

This block sits between the data-side master port of a cache and the bus interface unit, with a Wishbone-style handshake on both sides. A store from the cache is written into a small in-order queue and acknowledged in the same cycle. The processor therefore never waits for the slower downstream write. The block then replays the queued stores onto the downstream bus on its own, one transfer at a time and oldest first.

Loads are never queued. A load is routed straight to the downstream side, but only once every earlier store has been written out. This keeps a load from overtaking a store to the same address. A bus error on a replayed store cannot be reported upstream, because that store was already acknowledged, so the error is dropped.

A mode input selects between buffered operation and a plain combinational connection of the two ports.

Top module: `wb_store_buffer`

## Requirements
- R1: With buffering on (`buf_en_i`=1), a store request (cyc, stb and we all 1) that arrives while the queue is not full gets `up_ack_o`=1 in the same cycle. This does not depend on any downstream signal.
- R2: Back-to-back stores are each acknowledged once and each stored as a separate entry. Four accepted stores produce exactly four downstream writes and no more.
- R3: Queued stores are issued downstream with `dn_we_o`=1, oldest first, carrying the address, data and byte selects they were accepted with.
- R4: While a queued write waits for `dn_ack_i`, `dn_cyc_o` and `dn_stb_o` stay 1 and the address, data and selects stay stable. The entry is removed on the edge where `dn_ack_i` or `dn_err_i` is 1, and the next entry is presented in the following cycle.
- R5: A load (cyc=1, stb=1, we=0) that arrives while the queue holds entries is not acknowledged and is not driven downstream until the last queued write has completed.
- R6: A load with buffering on and the queue empty is connected straight through in the same cycle. The downstream side sees the load's address with `dn_we_o`=0. `up_ack_o` follows `dn_ack_i`, and `up_dat_o` follows `dn_dat_i`.
- R7: With `buf_en_i`=0 every upstream signal is passed straight to the downstream port, and `up_ack_o` follows `dn_ack_i`. Stores made in this mode are never queued.
- R8: A `dn_err_i` on a queued write removes that entry like an acknowledge and never shows up on `up_err_o`.
- R9: The queue holds 4 entries. A store that arrives while all 4 are held keeps `up_ack_o`=0. It is acknowledged in the cycle after a downstream write completes.
- R10: After reset, with no request present, `dn_cyc_o`=0 and `up_ack_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| buf_en_i | input | 1 | 1 = buffered mode, 0 = direct connection |
| up_cyc_i | input | 1 | Upstream bus cycle |
| up_stb_i | input | 1 | Upstream strobe |
| up_we_i | input | 1 | Upstream write enable (1 = store) |
| up_adr_i | input | 32 | Upstream address |
| up_dat_i | input | 32 | Upstream write data |
| up_sel_i | input | 4 | Upstream byte selects |
| up_dat_o | output | 32 | Read data returned upstream |
| up_ack_o | output | 1 | Upstream acknowledge |
| up_err_o | output | 1 | Upstream bus error |
| dn_cyc_o | output | 1 | Downstream bus cycle |
| dn_stb_o | output | 1 | Downstream strobe |
| dn_we_o | output | 1 | Downstream write enable |
| dn_adr_o | output | 32 | Downstream address |
| dn_dat_o | output | 32 | Downstream write data |
| dn_sel_o | output | 4 | Downstream byte selects |
| dn_dat_i | input | 32 | Downstream read data |
| dn_ack_i | input | 1 | Downstream acknowledge |
| dn_err_i | input | 1 | Downstream bus error |

## Verification
The posting path is tested with a burst of four stores to one address. Because every data value differs, any reordering or dropped entry shows up in the downstream data sequence. Wait states are inserted between downstream acknowledges, which separates a write that is held correctly from one that advances early. A separate fill-and-overflow sequence distinguishes a full queue that refuses work from one that overwrites its oldest entry. Single-cycle loads and stores in both modes distinguish the direct connection from the gated load path, and the error-return case shows whether a dropped error still removes its entry.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int SEL_W  = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] dat;
        logic [SEL_W-1:0]  sel;
    } sb_entry_t;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      push_i,
    input  logic      pop_i,
    input  sb_entry_t entry_i,
    output sb_entry_t head_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        sb_entry_t [DEPTH-1:0] slot;
        logic [IDX_W-1:0]      wr;
        logic [IDX_W-1:0]      rd;
        logic [CNT_W-1:0]      cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic do_push, do_pop;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == FULL_CNT);
    assign head_o  = s_q.slot[s_q.rd];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.slot[s_q.wr] = entry_i;
            s_d.wr           = wrap_inc(s_q.wr);
        end
        if (do_pop) begin
            s_d.rd = wrap_inc(s_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sb_route.sv
module sb_route
    import sb_pkg::*;
(
    input  logic              buf_en_i,
    input  logic              q_empty_i,
    input  logic              q_full_i,
    input  sb_entry_t         q_head_i,
    input  logic              up_cyc_i,
    input  logic              up_stb_i,
    input  logic              up_we_i,
    input  logic [ADDR_W-1:0] up_adr_i,
    input  logic [DATA_W-1:0] up_dat_i,
    input  logic [SEL_W-1:0]  up_sel_i,
    output logic [DATA_W-1:0] up_dat_o,
    output logic              up_ack_o,
    output logic              up_err_o,
    output logic              dn_cyc_o,
    output logic              dn_stb_o,
    output logic              dn_we_o,
    output logic [ADDR_W-1:0] dn_adr_o,
    output logic [DATA_W-1:0] dn_dat_o,
    output logic [SEL_W-1:0]  dn_sel_o,
    input  logic [DATA_W-1:0] dn_dat_i,
    input  logic              dn_ack_i,
    input  logic              dn_err_i,
    output logic              push_o,
    output logic              pop_o
);
    logic is_store, is_load;

    assign is_store = up_cyc_i && up_stb_i && up_we_i;
    assign is_load  = up_cyc_i && up_stb_i && !up_we_i;
    assign up_dat_o = dn_dat_i;

    always_comb begin
        dn_cyc_o = 1'b0;
        dn_stb_o = 1'b0;
        dn_we_o  = 1'b0;
        dn_adr_o = up_adr_i;
        dn_dat_o = up_dat_i;
        dn_sel_o = up_sel_i;
        up_ack_o = 1'b0;
        up_err_o = 1'b0;
        push_o   = 1'b0;
        pop_o    = 1'b0;
        if (!buf_en_i) begin
            dn_cyc_o = up_cyc_i;
            dn_stb_o = up_stb_i;
            dn_we_o  = up_we_i;
            up_ack_o = dn_ack_i;
            up_err_o = dn_err_i;
        end else begin
            push_o = is_store && !q_full_i;
            if (is_store) begin
                up_ack_o = !q_full_i;
            end
            if (!q_empty_i) begin
                dn_cyc_o = 1'b1;
                dn_stb_o = 1'b1;
                dn_we_o  = 1'b1;
                dn_adr_o = q_head_i.adr;
                dn_dat_o = q_head_i.dat;
                dn_sel_o = q_head_i.sel;
                pop_o    = dn_ack_i || dn_err_i;
            end else if (is_load) begin
                dn_cyc_o = 1'b1;
                dn_stb_o = 1'b1;
                up_ack_o = dn_ack_i;
                up_err_o = dn_err_i;
            end
        end
    end
endmodule

// File: rtl/wb_store_buffer.sv
module wb_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              buf_en_i,
    input  logic              up_cyc_i,
    input  logic              up_stb_i,
    input  logic              up_we_i,
    input  logic [ADDR_W-1:0] up_adr_i,
    input  logic [DATA_W-1:0] up_dat_i,
    input  logic [SEL_W-1:0]  up_sel_i,
    output logic [DATA_W-1:0] up_dat_o,
    output logic              up_ack_o,
    output logic              up_err_o,
    output logic              dn_cyc_o,
    output logic              dn_stb_o,
    output logic              dn_we_o,
    output logic [ADDR_W-1:0] dn_adr_o,
    output logic [DATA_W-1:0] dn_dat_o,
    output logic [SEL_W-1:0]  dn_sel_o,
    input  logic [DATA_W-1:0] dn_dat_i,
    input  logic              dn_ack_i,
    input  logic              dn_err_i
);
    sb_entry_t new_entry, head;
    logic      q_empty, q_full, q_push, q_pop;

    assign new_entry = '{adr: up_adr_i, dat: up_dat_i, sel: up_sel_i};

    sb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (q_push),
        .pop_i   (q_pop),
        .entry_i (new_entry),
        .head_o  (head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    sb_route u_route (
        .buf_en_i  (buf_en_i),
        .q_empty_i (q_empty),
        .q_full_i  (q_full),
        .q_head_i  (head),
        .up_cyc_i  (up_cyc_i),
        .up_stb_i  (up_stb_i),
        .up_we_i   (up_we_i),
        .up_adr_i  (up_adr_i),
        .up_dat_i  (up_dat_i),
        .up_sel_i  (up_sel_i),
        .up_dat_o  (up_dat_o),
        .up_ack_o  (up_ack_o),
        .up_err_o  (up_err_o),
        .dn_cyc_o  (dn_cyc_o),
        .dn_stb_o  (dn_stb_o),
        .dn_we_o   (dn_we_o),
        .dn_adr_o  (dn_adr_o),
        .dn_dat_o  (dn_dat_o),
        .dn_sel_o  (dn_sel_o),
        .dn_dat_i  (dn_dat_i),
        .dn_ack_i  (dn_ack_i),
        .dn_err_i  (dn_err_i),
        .push_o    (q_push),
        .pop_o     (q_pop)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              buf_en_i,
    input logic              up_cyc_i,
    input logic              up_stb_i,
    input logic              up_we_i,
    input logic [ADDR_W-1:0] up_adr_i,
    input logic              up_ack_o,
    input logic              up_err_o,
    input logic              dn_cyc_o,
    input logic              dn_stb_o,
    input logic              dn_we_o,
    input logic [ADDR_W-1:0] dn_adr_o,
    input logic [DATA_W-1:0] dn_dat_o,
    input logic [SEL_W-1:0]  dn_sel_o,
    input logic              dn_ack_i,
    input logic              dn_err_i
);
    localparam int OCC_W = $clog2(DEPTH + 2);

    logic [OCC_W-1:0] occ_d, occ_q;
    logic st_req, ld_req, acc, done;

    assign st_req = up_cyc_i && up_stb_i && up_we_i;
    assign ld_req = up_cyc_i && up_stb_i && !up_we_i;
    assign acc    = buf_en_i && st_req && up_ack_o;
    assign done   = buf_en_i && dn_cyc_o && dn_we_o && (dn_ack_i || dn_err_i);

    always_comb begin
        occ_d = occ_q + OCC_W'(acc) - OCC_W'(done);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) occ_q <= '0;
        else       occ_q <= occ_d;
    end

    AST_STORE_POSTED: assert property (@(posedge clk_i) disable iff (rst_i)
        acc |=> (!buf_en_i || (dn_cyc_o && dn_we_o))); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        occ_q <= OCC_W'(DEPTH)); // R9

    AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
        (buf_en_i && st_req && occ_q == OCC_W'(DEPTH)) |-> !up_ack_o); // R9

    AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (buf_en_i && dn_cyc_o && dn_we_o && !dn_ack_i && !dn_err_i) |=>
        (!buf_en_i || (dn_cyc_o && dn_stb_o && dn_we_o && $stable(dn_adr_o)
                       && $stable(dn_dat_o) && $stable(dn_sel_o)))); // R4

    AST_LOAD_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (buf_en_i && ld_req && occ_q != '0) |-> (!up_ack_o && dn_we_o)); // R5

    AST_STORE_NO_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        (buf_en_i && st_req) |-> !up_err_o); // R8

    AST_DIRECT_PATH: assert property (@(posedge clk_i) disable iff (rst_i)
        !buf_en_i |-> (dn_adr_o == up_adr_i && up_ack_o == dn_ack_i
                       && dn_we_o == up_we_i)); // R7
endmodule

bind wb_store_buffer sb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .buf_en_i (buf_en_i),
    .up_cyc_i (up_cyc_i),
    .up_stb_i (up_stb_i),
    .up_we_i  (up_we_i),
    .up_adr_i (up_adr_i),
    .up_ack_o (up_ack_o),
    .up_err_o (up_err_o),
    .dn_cyc_o (dn_cyc_o),
    .dn_stb_o (dn_stb_o),
    .dn_we_o  (dn_we_o),
    .dn_adr_o (dn_adr_o),
    .dn_dat_o (dn_dat_o),
    .dn_sel_o (dn_sel_o),
    .dn_ack_i (dn_ack_i),
    .dn_err_i (dn_err_i)
);

// File: tb/sim_wb_store_buffer.sv
module sim_wb_store_buffer;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        buf_en_i = 1'b1;
    logic        up_cyc_i = 1'b0, up_stb_i = 1'b0, up_we_i = 1'b0;
    logic [31:0] up_adr_i = '0, up_dat_i = '0;
    logic [3:0]  up_sel_i = '0;
    logic [31:0] up_dat_o;
    logic        up_ack_o, up_err_o;
    logic        dn_cyc_o, dn_stb_o, dn_we_o;
    logic [31:0] dn_adr_o, dn_dat_o;
    logic [3:0]  dn_sel_o;
    logic [31:0] dn_dat_i = '0;
    logic        dn_ack_i = 1'b0, dn_err_i = 1'b0;

    int tests = 0;
    int fails = 0;

    always #2 clk_i = ~clk_i;

    wb_store_buffer u0 (.*);

    typedef struct packed {
        logic        en;
        logic        we;
        logic [31:0] adr;
        logic [31:0] wdat;
        logic        dack;
        logic [31:0] rdat;
        logic        exp_ack;
        logic        exp_we;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 32'h40, 32'hAAAA_0001, 1'b0, 32'h0,         1'b0, 1'b1},
        '{1'b0, 1'b1, 32'h40, 32'hAAAA_0002, 1'b1, 32'h0,         1'b1, 1'b1},
        '{1'b0, 1'b0, 32'h44, 32'h0,         1'b1, 32'h1234_5678, 1'b1, 1'b0},
        '{1'b1, 1'b0, 32'h48, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0},
        '{1'b1, 1'b0, 32'h4C, 32'h0,         1'b1, 32'h5555_AAAA, 1'b1, 1'b0},
        '{1'b0, 1'b0, 32'h50, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        #1;
    endtask

    task automatic go_idle();
        up_cyc_i = 1'b0; up_stb_i = 1'b0; up_we_i = 1'b0;
        dn_ack_i = 1'b0; dn_err_i = 1'b0;
    endtask

    task automatic req(input logic we, input logic [31:0] adr, input logic [31:0] dat);
        up_cyc_i = 1'b1; up_stb_i = 1'b1; up_we_i = we;
        up_adr_i = adr; up_dat_i = dat; up_sel_i = 4'hF;
    endtask

    task automatic do_reset();
        go_idle();
        rst_i = 1'b1;
        step(); step();
        rst_i = 1'b0;
        #1;
    endtask

    initial begin
        #(4 * 50000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        chk("R10 dn_cyc after reset", {31'b0, dn_cyc_o}, 32'd0);
        chk("R10 up_ack after reset", {31'b0, up_ack_o}, 32'd0);

        // table: direct connection and empty-queue loads, no clock edges
        foreach (VECS[i]) begin
            buf_en_i = VECS[i].en;
            req(VECS[i].we, VECS[i].adr, VECS[i].wdat);
            dn_ack_i = VECS[i].dack;
            dn_dat_i = VECS[i].rdat;
            #1;
            chk(VECS[i].en ? "R6 up_ack" : "R7 up_ack", {31'b0, up_ack_o}, {31'b0, VECS[i].exp_ack});
            chk(VECS[i].en ? "R6 dn_we" : "R7 dn_we", {31'b0, dn_we_o}, {31'b0, VECS[i].exp_we});
            chk(VECS[i].en ? "R6 dn_adr" : "R7 dn_adr", dn_adr_o, VECS[i].adr);
            chk(VECS[i].en ? "R6 dn_cyc" : "R7 dn_cyc", {31'b0, dn_cyc_o}, 32'd1);
            if (VECS[i].exp_ack && !VECS[i].we)
                chk(VECS[i].en ? "R6 up_dat" : "R7 up_dat", up_dat_o, VECS[i].rdat);
        end
        go_idle();
        buf_en_i = 1'b1;
        step();

        // R7: stores in direct mode are not queued
        buf_en_i = 1'b0;
        req(1'b1, 32'h60, 32'hDEAD_0000);
        dn_ack_i = 1'b1;
        step(); step();
        go_idle();
        buf_en_i = 1'b1;
        #1;
        chk("R7 no entry queued", {31'b0, dn_cyc_o}, 32'd0);

        // four stores to one address, each acked at once (R1, R2)
        for (int k = 0; k < 4; k++) begin
            req(1'b1, 32'h100, 32'(k));
            #1;
            chk("R1 early ack", {31'b0, up_ack_o}, 32'd1);
            step();
        end
        // load waits while writes drain (R5)
        req(1'b0, 32'h100, 32'h0);
        #1;
        chk("R5 load not acked", {31'b0, up_ack_o}, 32'd0);
        chk("R5 downstream busy with write", {31'b0, dn_we_o}, 32'd1);
        step(); step();
        chk("R4 held without ack", dn_dat_o, 32'd0);
        for (int k = 0; k < 4; k++) begin
            chk("R3 write order data", dn_dat_o, 32'(k));
            chk("R3 write address", dn_adr_o, 32'h100);
            chk("R3 write flag", {31'b0, dn_we_o}, 32'd1);
            if (k == 1) dn_err_i = 1'b1;
            else        dn_ack_i = 1'b1;
            #1;
            chk("R5 load still stalled", {31'b0, up_ack_o}, 32'd0);
            chk("R8 no error upstream", {31'b0, up_err_o}, 32'd0);
            step();
            dn_ack_i = 1'b0; dn_err_i = 1'b0;
            if (k < 3) begin
                #1;
                chk("R4 stable during wait", dn_dat_o, 32'(k + 1));
                step();
            end
        end
        #1;
        chk("R2 no fifth write", {31'b0, dn_we_o}, 32'd0);
        chk("R6 load issued after drain", {31'b0, dn_cyc_o}, 32'd1);
        dn_dat_i = 32'hCAFE_F00D;
        dn_ack_i = 1'b1;
        #1;
        chk("R6 load acked", {31'b0, up_ack_o}, 32'd1);
        chk("R6 load data", up_dat_o, 32'hCAFE_F00D);
        step();
        go_idle();

        // full queue (R9)
        do_reset();
        for (int k = 0; k < 4; k++) begin
            req(1'b1, 32'h200 + 32'(4 * k), 32'h10 + 32'(k));
            step();
        end
        req(1'b1, 32'h210, 32'h14);
        #1;
        chk("R9 full no ack", {31'b0, up_ack_o}, 32'd0);
        step();
        chk("R9 full no ack later", {31'b0, up_ack_o}, 32'd0);
        dn_ack_i = 1'b1;
        #1;
        chk("R9 no ack in pop cycle", {31'b0, up_ack_o}, 32'd0);
        step();
        dn_ack_i = 1'b0;
        #1;
        chk("R9 ack after slot freed", {31'b0, up_ack_o}, 32'd1);
        step();
        up_cyc_i = 1'b0; up_stb_i = 1'b0;
        dn_ack_i = 1'b1;
        for (int k = 1; k < 5; k++) begin
            #1;
            chk("R3 order after refill", dn_dat_o, 32'h10 + 32'(k));
            chk("R3 address after refill", dn_adr_o, 32'h200 + 32'(4 * k));
            step();
        end
        #1;
        chk("R2 queue drained", {31'b0, dn_cyc_o}, 32'd0);
        go_idle();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule